// File: doc/BRIEF.md
# VLIW Execute-Packet Dispatcher

This block sits between a program-memory fetch port and the issue stage of a very-long-instruction-word core. Program memory delivers fetch packets of eight 32-bit instruction slots. Bit 0 of each instruction is a parallel flag. A 1 means the next instruction in address order runs in the same cycle. A 0 closes the group. The dispatcher walks each fetch packet from the lowest slot upward, cuts it into execute packets, and presents one execute packet per clock as an eight-lane instruction vector with a lane-valid mask.

Compiled code does not pad the end of a fetch packet with no-ops. A group can therefore start near the end of one fetch packet and finish in the next. The dispatcher copies the leading part of such a group into a carry buffer and requests the next fetch packet. It issues the complete group one cycle after that packet is accepted, with the carried instructions in the lowest lanes. A new fetch packet is requested only when nothing of the current one remains to dispatch.

The controller has two states. In `ST_FETCH` the block holds no fetch packet and raises `fp_ready`. In `ST_ISSUE` it holds one fetch packet and a slot pointer. The transitions are:
- `T_ACCEPT` (`ST_FETCH` to `ST_ISSUE`): a packet is accepted and the pointer is cleared.
- `T_NEXT_EP` (stays in `ST_ISSUE`): a group is dispatched and more slots remain.
- `T_DRAIN` (`ST_ISSUE` to `ST_FETCH`): the group that uses slot 7 is dispatched.
- `T_SPILL` (`ST_ISSUE` to `ST_FETCH`): the remaining slots form no complete group, so they move to the carry buffer.

Top module: `vliw_ep_dispatch`

## Requirements
- R1: In the first cycle after synchronous reset `fp_ready` is 1 and `disp_valid` is 0.
- R2: `fp_ready` is high only while no fetch packet is held. Data offered on `fp_data` while `fp_ready` is low has no effect on any dispatched instruction.
- R3: Slots are numbered from the lowest bits upward: slot s is `fp_data[32*s +: 32]`. An execute packet takes instructions in ascending slot order and ends at the first instruction whose bit 0 is 0. Its first instruction appears on lane 0, which is `disp_insn[31:0]`.
- R4: For a packet of N instructions, `disp_mask` has bits 0 to N-1 set and all other bits clear, and lanes N and above read zero. While `disp_valid` is 0, both the mask and the lanes read zero.
- R5: While `disp_ready` is 1, the execute packets of one fetch packet are dispatched in consecutive cycles, one per cycle.
- R6: In the cycle after the packet containing slot 7 is dispatched, `fp_ready` is 1.
- R7: Suppose every remaining slot has bit 0 set. Then in that cycle `disp_valid` is 0, and in the next cycle `fp_ready` is 1. In the cycle after the next fetch packet is accepted, the merged packet is dispatched: carried instructions come first in slot order, followed by the new packet's leading slots.
- R8: An execute packet closes once it holds eight instructions, even if the eighth has bit 0 set, and also when those eight span two fetch packets. The following instruction starts a new packet.
- R9: While `disp_valid` is 1 and `disp_ready` is 0, `disp_valid`, `disp_mask` and `disp_insn` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fp_valid | input | 1 | Fetch packet offered |
| fp_ready | output | 1 | Dispatcher accepts a fetch packet this cycle |
| fp_data | input | SLOTS*IW (256) | Fetch packet, slot s in bits IW*s upward |
| disp_valid | output | 1 | An execute packet is presented |
| disp_ready | input | 1 | Issue stage takes the presented packet |
| disp_insn | output | SLOTS*IW (256) | Instruction lanes, lane 0 in the low bits |
| disp_mask | output | SLOTS (8) | Lane-valid mask, contiguous from bit 0 |

## Verification
The outputs are decoded combinationally from the held packet, the pointer and the carry buffer. A wrong pointer therefore shows on the lanes in the same cycle: the wrong instruction appears on lane 0, or the mask length changes. A lost or stale carry count shows only later, in the cycle after the next fetch packet is accepted, as shifted lanes or a wrong mask width. A premature or missing fetch request appears as `fp_ready` rising one cycle early or late around the final group of a packet. For these reasons the directed scenarios check every dispatched packet lane by lane and sample `fp_ready` and `disp_valid` at each boundary cycle.

// File: rtl/vliw_disp_pkg.sv
package vliw_disp_pkg;

    typedef enum logic [0:0] {
        ST_FETCH = 1'b0,
        ST_ISSUE = 1'b1
    } disp_state_e;

endpackage

// File: rtl/vd_scan.sv
// Finds where the current execute packet closes inside the held fetch packet.
module vd_scan #(
    parameter int SLOTS = 8,
    parameter int PW    = 3,
    parameter int CW    = 4
) (
    input  logic [SLOTS-1:0] cont,
    input  logic [PW-1:0]    ptr,
    input  logic [CW-1:0]    carry_cnt,
    output logic             closed,
    output logic [CW-1:0]    take
);

    always_comb begin
        closed = 1'b0;
        take   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!closed && (i >= int'(ptr))) begin
                take = take + CW'(1);
                if (!cont[i] || ((carry_cnt + take) == CW'(SLOTS))) begin
                    closed = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vd_merge.sv
// Places carried instructions in the low lanes, then the slots taken from the held packet.
module vd_merge #(
    parameter int SLOTS = 8,
    parameter int IW    = 32,
    parameter int PW    = 3,
    parameter int CW    = 4
) (
    input  logic [SLOTS*IW-1:0] slots,
    input  logic [SLOTS*IW-1:0] carry,
    input  logic [PW-1:0]       ptr,
    input  logic [CW-1:0]       carry_cnt,
    input  logic [CW-1:0]       take,
    output logic [SLOTS*IW-1:0] lanes,
    output logic [SLOTS-1:0]    mask
);

    for (genvar k = 0; k < SLOTS; k++) begin : g_lane
        always_comb begin
            int src;
            src                = k - int'(carry_cnt);
            lanes[k*IW +: IW]  = '0;
            mask[k]            = 1'b0;
            if (k < int'(carry_cnt)) begin
                lanes[k*IW +: IW] = carry[k*IW +: IW];
                mask[k]           = 1'b1;
            end else if (src < int'(take)) begin
                mask[k] = 1'b1;
                for (int j = 0; j < SLOTS; j++) begin
                    if (j == int'(ptr) + src) begin
                        lanes[k*IW +: IW] = slots[j*IW +: IW];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/vliw_ep_dispatch.sv
module vliw_ep_dispatch
    import vliw_disp_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int IW    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fp_valid,
    output logic                fp_ready,
    input  logic [SLOTS*IW-1:0] fp_data,
    output logic                disp_valid,
    input  logic                disp_ready,
    output logic [SLOTS*IW-1:0] disp_insn,
    output logic [SLOTS-1:0]    disp_mask
);

    localparam int PW = $clog2(SLOTS);
    localparam int CW = $clog2(SLOTS + 1);
    localparam int FW = SLOTS * IW;

    disp_state_e       state_q, state_d;
    logic [FW-1:0]     held_q;
    logic [FW-1:0]     carry_q;
    logic [PW-1:0]     ptr_q;
    logic [CW-1:0]     cc_q;

    logic [SLOTS-1:0]  cont;
    logic              closed;
    logic [CW-1:0]     take;
    logic [FW-1:0]     lanes;
    logic [SLOTS-1:0]  mask;
    logic [CW:0]       end_pos;
    logic              last_ep;

    for (genvar s = 0; s < SLOTS; s++) begin : g_cont
        assign cont[s] = held_q[s*IW];
    end

    vd_scan #(.SLOTS(SLOTS), .PW(PW), .CW(CW)) u_scan (
        .cont      (cont),
        .ptr       (ptr_q),
        .carry_cnt (cc_q),
        .closed    (closed),
        .take      (take)
    );

    vd_merge #(.SLOTS(SLOTS), .IW(IW), .PW(PW), .CW(CW)) u_merge (
        .slots     (held_q),
        .carry     (carry_q),
        .ptr       (ptr_q),
        .carry_cnt (cc_q),
        .take      (take),
        .lanes     (lanes),
        .mask      (mask)
    );

    assign end_pos = (CW+1)'(ptr_q) + (CW+1)'(take);
    assign last_ep = (end_pos == (CW+1)'(SLOTS));

    // Next-state logic: T_ACCEPT, T_SPILL, T_DRAIN, T_NEXT_EP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: begin
                if (fp_valid) state_d = ST_ISSUE;              // T_ACCEPT
            end
            ST_ISSUE: begin
                if (!closed) state_d = ST_FETCH;               // T_SPILL
                else if (disp_ready && last_ep) state_d = ST_FETCH; // T_DRAIN
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            carry_q <= '0;
            ptr_q   <= '0;
            cc_q    <= '0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    if (fp_valid) begin
                        held_q <= fp_data;
                        ptr_q  <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (!closed) begin
                        carry_q <= lanes;
                        cc_q    <= cc_q + take;
                    end else if (disp_ready) begin
                        cc_q  <= '0;
                        ptr_q <= PW'(end_pos);
                    end
                end
            endcase
        end
    end

    always_comb begin
        fp_ready   = (state_q == ST_FETCH);
        disp_valid = (state_q == ST_ISSUE) && closed;
        disp_insn  = disp_valid ? lanes : '0;
        disp_mask  = disp_valid ? mask  : '0;
    end

    // ---------------- assertions ----------------
    logic [SLOTS:0] mext;
    logic           last_ok;
    assign mext = {1'b0, disp_mask};

    always_comb begin
        last_ok = 1'b1;
        for (int k = 0; k < SLOTS; k++) begin
            if (mext[k] && !mext[k+1] && (disp_mask != '1) && disp_insn[k*IW]) begin
                last_ok = 1'b0;
            end
        end
    end

    a_r1_fetch_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fp_ready && !disp_valid));

    a_r2_no_fetch_while_held: assert property (@(posedge clk) disable iff (rst)
        !(fp_ready && disp_valid));

    a_r3_last_lane_closes: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> last_ok);

    a_r4_mask_contiguous: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> ((disp_mask != '0) &&
                        ((disp_mask & SLOTS'(disp_mask + 1'b1)) == '0)));

    a_r8_carry_bounded: assert property (@(posedge clk) disable iff (rst)
        cc_q < CW'(SLOTS));

    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ready) |=>
            (disp_valid && $stable(disp_mask) && $stable(disp_insn)));

endmodule

// File: tb/test_vliw_ep_dispatch.sv
module test_vliw_ep_dispatch;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         fp_valid;
    logic         fp_ready;
    logic [255:0] fp_data;
    logic         disp_valid;
    logic         disp_ready;
    logic [255:0] disp_insn;
    logic [7:0]   disp_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [255:0] exp_v;
    int           exp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    vliw_ep_dispatch i_vliw_ep_dispatch (
        .clk        (clk),
        .rst        (rst),
        .fp_valid   (fp_valid),
        .fp_ready   (fp_ready),
        .fp_data    (fp_data),
        .disp_valid (disp_valid),
        .disp_ready (disp_ready),
        .disp_insn  (disp_insn),
        .disp_mask  (disp_mask)
    );

    function automatic logic [31:0] ins(int base, logic [7:0] par, int s);
        logic [30:0] id;
        id = 31'(base + s);
        return {id, par[s]};
    endfunction

    function automatic logic [255:0] mk_fp(int base, logic [7:0] par);
        logic [255:0] v;
        for (int s = 0; s < 8; s++) v[s*32 +: 32] = ins(base, par, s);
        return v;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ex_clear();
        exp_v = '0;
        exp_n = 0;
    endtask

    task automatic ex_add(int base, logic [7:0] par, int s);
        exp_v[exp_n*32 +: 32] = ins(base, par, s);
        exp_n++;
    endtask

    // Offer a fetch packet and return at the negedge after it is accepted.
    task automatic push(int base, logic [7:0] par);
        fp_valid = 1'b1;
        fp_data  = mk_fp(base, par);
        while (!fp_ready) step();
        step();
        fp_valid = 1'b0;
        fp_data  = '0;
    endtask

    // Compare the presented packet against exp_v/exp_n, then let it go.
    task automatic check_ep(string req);
        logic [7:0] em;
        em = 8'((16'd1 << exp_n) - 16'd1);
        chk(disp_valid == 1'b1, {req, " disp_valid"}, 256'(disp_valid), 256'(1));
        chk(disp_mask == em, {req, " disp_mask"}, 256'(disp_mask), 256'(em));
        chk(disp_insn == exp_v, {req, " lanes"}, disp_insn, exp_v);
        step();
    endtask

    task automatic single(string req, int base, logic [7:0] par, int s);
        ex_clear();
        ex_add(base, par, s);
        check_ep(req);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        fp_valid = 1'b0;
        fp_data = '0;
        disp_ready = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk(fp_ready == 1'b1, "R1 fp_ready after reset", 256'(fp_ready), 256'(1));
        chk(disp_valid == 1'b0, "R1 disp_valid after reset", 256'(disp_valid), 256'(0));
        chk(disp_mask == 8'h00, "R4 idle mask", 256'(disp_mask), 256'(0));
    endtask

    // All singles; a competing packet is offered throughout and must be ignored.
    task automatic t_singles();
        push(32'h100, 8'h00);
        fp_valid = 1'b1;
        fp_data  = mk_fp(32'h900, 8'h00);
        for (int s = 0; s < 8; s++) begin
            chk(fp_ready == 1'b0, "R2 no fetch while held", 256'(fp_ready), 256'(0));
            if (s == 7) begin
                fp_valid = 1'b0;
                fp_data  = '0;
            end
            single("R5 R3 single", 32'h100, 8'h00, s);
        end
        chk(fp_ready == 1'b1, "R6 fetch after slot 7", 256'(fp_ready), 256'(1));
        chk(disp_valid == 1'b0, "R6 idle after drain", 256'(disp_valid), 256'(0));
    endtask

    // Groups of 3, 2, 3 inside one packet.
    task automatic t_groups();
        logic [7:0] p;
        p = 8'h6B;
        push(32'h200, p);
        ex_clear(); ex_add(32'h200, p, 0); ex_add(32'h200, p, 1); ex_add(32'h200, p, 2);
        check_ep("R3 R4 group a");
        ex_clear(); ex_add(32'h200, p, 3); ex_add(32'h200, p, 4);
        check_ep("R3 R4 group b");
        ex_clear(); ex_add(32'h200, p, 5); ex_add(32'h200, p, 6); ex_add(32'h200, p, 7);
        check_ep("R5 R4 group c");
        chk(fp_ready == 1'b1, "R6 fetch after groups", 256'(fp_ready), 256'(1));
    endtask

    // A group spanning two fetch packets.
    task automatic t_span();
        logic [7:0] pa, pb;
        pa = 8'hEE;
        pb = 8'h01;
        push(32'h300, pa);
        single("R3 span lead", 32'h300, pa, 0);
        ex_clear();
        for (int s = 1; s <= 4; s++) ex_add(32'h300, pa, s);
        check_ep("R3 span mid");
        chk(disp_valid == 1'b0, "R7 no dispatch on spill", 256'(disp_valid), 256'(0));
        chk(fp_ready == 1'b0, "R7 spill cycle", 256'(fp_ready), 256'(0));
        step();
        chk(fp_ready == 1'b1, "R7 fetch after spill", 256'(fp_ready), 256'(1));
        push(32'h400, pb);
        ex_clear();
        for (int s = 5; s <= 7; s++) ex_add(32'h300, pa, s);
        ex_add(32'h400, pb, 0);
        ex_add(32'h400, pb, 1);
        check_ep("R7 merged packet");
        for (int s = 2; s < 8; s++) single("R5 after merge", 32'h400, pb, s);
        chk(fp_ready == 1'b1, "R6 fetch after merge packet", 256'(fp_ready), 256'(1));
    endtask

    // Eight-instruction cap, within a packet and across a boundary.
    task automatic t_cap();
        ex_clear();
        push(32'h500, 8'hFF);
        for (int s = 0; s < 8; s++) ex_add(32'h500, 8'hFF, s);
        check_ep("R8 full packet cap");
        chk(fp_ready == 1'b1, "R8 fetch after cap", 256'(fp_ready), 256'(1));

        push(32'h600, 8'hFE);
        single("R8 before carry", 32'h600, 8'hFE, 0);
        chk(disp_valid == 1'b0, "R7 spill of seven", 256'(disp_valid), 256'(0));
        push(32'h700, 8'hFF);
        ex_clear();
        for (int s = 1; s < 8; s++) ex_add(32'h600, 8'hFE, s);
        ex_add(32'h700, 8'hFF, 0);
        check_ep("R8 cap across boundary");
        chk(disp_valid == 1'b0, "R7 second spill", 256'(disp_valid), 256'(0));
        push(32'h800, 8'h00);
        ex_clear();
        for (int s = 1; s < 8; s++) ex_add(32'h700, 8'hFF, s);
        ex_add(32'h800, 8'h00, 0);
        check_ep("R8 cap after restart");
        single("R8 next packet starts", 32'h800, 8'h00, 1);
        for (int s = 2; s < 8; s++) single("R5 tail", 32'h800, 8'h00, s);
    endtask

    // Back-pressure holds the presented packet.
    task automatic t_stall();
        logic [7:0] p;
        logic [255:0] snap;
        p = 8'h03;
        disp_ready = 1'b0;
        push(32'hA00, p);
        ex_clear(); ex_add(32'hA00, p, 0); ex_add(32'hA00, p, 1); ex_add(32'hA00, p, 2);
        snap = disp_insn;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(disp_valid == 1'b1, "R9 valid held", 256'(disp_valid), 256'(1));
            chk(disp_insn == snap, "R9 lanes held", disp_insn, snap);
            chk(disp_mask == 8'h07, "R9 mask held", 256'(disp_mask), 256'(8'h07));
        end
        disp_ready = 1'b1;
        check_ep("R9 released packet");
        for (int s = 3; s < 8; s++) single("R5 after stall", 32'hA00, p, s);
        chk(fp_ready == 1'b1, "R6 fetch after stall run", 256'(fp_ready), 256'(1));
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_singles();
        t_groups();
        t_span();
        t_cap();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule